// File: doc/BRIEF.md
# Carrier Sign Delay Rectifier

This block turns a signed demodulator result stream into a rectified one. It picks a carrier sign from one of four sources and delays every transition of that sign by a programmable number of clock cycles, so that the sign lines up with the latency of the filter that produced the results. When rectification is on and the delayed sign says the carrier is in its negative half-wave, each incoming result is negated on its way to the output. Negation saturates, so the most negative input comes out as the most positive value.

The block also measures the lag between the carrier and the data. A counter restarts on every transition of the selected carrier sign. When the sign bit of an incoming result changes, the counter value is captured and a sticky valid flag is set. The flag stays set until a read strobe clears it. Software uses the captured lag to tune the two half-wave delays, which are set separately.

Top module: `sign_delay_rectifier`

## Requirements
- R1: With `rect_en` low, every result passes to `out_data` unchanged, whatever the delayed sign is.
- R2: `out_valid` and `out_data` come one clock after `in_valid`/`in_data`. With `rect_en` high, a result is negated when `dly_sign` is 1 (negative half-wave) and passed unchanged when `dly_sign` is 0 (positive half-wave).
- R3: Negating the most negative input value gives the most positive value. It does not wrap.
- R4: `sign_src` selects the carrier sign shown on `sel_sign` without delay: 0 selects `sgn_carrier`, 1 selects `sgn_next`, 2 selects `sgn_ext_a` and 3 selects `sgn_ext_b`. The value 0 means positive and 1 means negative.
- R5: After `sel_sign` changes and stays steady, `dly_sign` takes the new value at the clock edge where `sd_count` reads D, which is D+2 edges after the first edge that sees the change. D is `dly_neg` for a change to 1 and `dly_pos` for a change to 0.
- R6: If the selected sign returns to its old value before its delay has elapsed, `dly_sign` does not change.
- R7: `sd_count` reads 0 in the cycle after each selected-sign transition. It then rises by one per clock and holds at 127.
- R8: When a valid result has a sign bit different from the previous valid result, `sd_cap` takes the `sd_count` value of that cycle and `sd_valid` is set. The sign of the previous result is taken as 0 after reset.
- R9: A high `cap_rd` clears `sd_valid` on the next edge. If a new capture happens in the same cycle, the capture wins and `sd_valid` stays 1.
- R10: After reset, `out_valid`, `dly_sign`, `sd_count`, `sd_cap` and `sd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input result strobe |
| in_data | input | DW | Signed input result |
| sgn_carrier | input | 1 | Sign from the on-chip carrier generator |
| sgn_next | input | 1 | Sign of the neighbouring channel's result |
| sgn_ext_a | input | 1 | External sign A |
| sgn_ext_b | input | 1 | External sign B |
| sign_src | input | 2 | Carrier sign source select |
| rect_en | input | 1 | Rectification enable |
| dly_pos | input | CW | Delay for a change to the positive half-wave |
| dly_neg | input | CW | Delay for a change to the negative half-wave |
| cap_rd | input | 1 | Capture read strobe; clears `sd_valid` |
| out_valid | output | 1 | Output result strobe |
| out_data | output | DW | Rectified result |
| sel_sign | output | 1 | Selected carrier sign |
| dly_sign | output | 1 | Delayed carrier sign |
| sd_count | output | CW | Sign delay counter |
| sd_cap | output | CW | Captured sign delay |
| sd_valid | output | 1 | Capture valid flag |

## Verification
The data path is driven four ways:
- Positive and negative values with rectification off. This separates the enable from the sign.
- The same values during each half-wave. This shows that negation follows the delayed sign and not the selected one.
- The most negative value. This separates saturation from two's-complement wrap.
- Zero. This shows that the identity holds at the sign boundary.

The delay logic is driven three ways:
- Steady transitions with different positive and negative delays. These check the exact edge of each change and which delay applies.
- A pulse shorter than its delay. This must be dropped.
- A hold long enough to reach counter saturation.

The capture logic is driven two ways:
- A sign flip of the result at a known counter value.
- A flip in the same cycle as a read. This checks which of the two wins.

// File: rtl/sign_delay_rectifier.sv
module sign_delay_rectifier #(
  parameter int DW = 16,
  parameter int CW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 sgn_carrier,
  input  logic                 sgn_next,
  input  logic                 sgn_ext_a,
  input  logic                 sgn_ext_b,
  input  logic [1:0]           sign_src,
  input  logic                 rect_en,
  input  logic [CW-1:0]        dly_pos,
  input  logic [CW-1:0]        dly_neg,
  input  logic                 cap_rd,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic                 sel_sign,
  output logic                 dly_sign,
  output logic [CW-1:0]        sd_count,
  output logic [CW-1:0]        sd_cap,
  output logic                 sd_valid
);
  localparam logic [CW-1:0]        CNT_MAX = '1;
  localparam logic signed [DW-1:0] S_MIN   = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] S_MAX   = ~S_MIN;

  logic            sel_q;
  logic            res_sgn_q;
  logic            sel_edge;
  logic [CW-1:0]   dly_lim;
  logic            cap_hit;
  logic signed [DW-1:0] neg_data;

  always_comb begin
    case (sign_src)
      2'd0:    sel_sign = sgn_carrier;
      2'd1:    sel_sign = sgn_next;
      2'd2:    sel_sign = sgn_ext_a;
      default: sel_sign = sgn_ext_b;
    endcase
  end

  assign sel_edge = sel_sign != sel_q;
  assign dly_lim  = sel_q ? dly_neg : dly_pos;
  assign cap_hit  = in_valid && (in_data[DW-1] != res_sgn_q);
  assign neg_data = (in_data == S_MIN) ? S_MAX : -in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      sd_count <= '0;
      dly_sign <= 1'b0;
    end else begin
      sel_q <= sel_sign;
      if (sel_edge)
        sd_count <= '0;
      else if (sd_count != CNT_MAX)
        sd_count <= sd_count + 1'b1;
      if (!sel_edge && dly_sign != sel_q && sd_count == dly_lim)
        dly_sign <= sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_sgn_q <= 1'b0;
      sd_cap    <= '0;
      sd_valid  <= 1'b0;
    end else begin
      if (in_valid)
        res_sgn_q <= in_data[DW-1];
      if (cap_hit) begin
        sd_cap   <= sd_count;
        sd_valid <= 1'b1;
      end else if (cap_rd) begin
        sd_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= (rect_en && dly_sign) ? neg_data : in_data;
    end
  end
endmodule

module sdr_checker #(
  parameter int DW = 16,
  parameter int CW = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_data,
  input logic                 rect_en,
  input logic                 cap_rd,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data,
  input logic [CW-1:0]        sd_count,
  input logic [CW-1:0]        sd_cap,
  input logic                 sd_valid
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  AST_OUT_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rect_en) |=> out_data == $past(in_data)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_count != '0) |-> (sd_count == $past(sd_count) + 1'b1) ||
                         (sd_count == CNT_MAX && $past(sd_count) == CNT_MAX)); // R7
  AST_CAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cap != $past(sd_cap)) |-> sd_valid); // R8
  AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_valid) |-> $past(cap_rd)); // R9
endmodule

bind sign_delay_rectifier sdr_checker #(.DW(DW), .CW(CW)) u_sdr_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .rect_en(rect_en), .cap_rd(cap_rd), .out_valid(out_valid),
  .out_data(out_data), .sd_count(sd_count), .sd_cap(sd_cap),
  .sd_valid(sd_valid)
);

// File: tb/test_sign_delay_rectifier.sv
module test_sign_delay_rectifier;
  localparam int DW = 16;
  localparam int CW = 7;
  localparam logic signed [DW-1:0] S_MIN = 16'sh8000;
  localparam logic signed [DW-1:0] S_MAX = 16'sh7fff;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic sgn_carrier = 1'b0, sgn_next = 1'b0, sgn_ext_a = 1'b0, sgn_ext_b = 1'b0;
  logic [1:0] sign_src = 2'd0;
  logic rect_en = 1'b0;
  logic [CW-1:0] dly_pos = 7'd2;
  logic [CW-1:0] dly_neg = 7'd5;
  logic cap_rd = 1'b0;
  logic out_valid;
  logic signed [DW-1:0] out_data;
  logic sel_sign, dly_sign, sd_valid;
  logic [CW-1:0] sd_count, sd_cap;

  int checks = 0;
  int fails  = 0;
  logic signed [DW-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sign_delay_rectifier #(.DW(DW), .CW(CW)) i_sign_delay_rectifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .sgn_carrier(sgn_carrier), .sgn_next(sgn_next), .sgn_ext_a(sgn_ext_a),
    .sgn_ext_b(sgn_ext_b), .sign_src(sign_src), .rect_en(rect_en),
    .dly_pos(dly_pos), .dly_neg(dly_neg), .cap_rd(cap_rd),
    .out_valid(out_valid), .out_data(out_data), .sel_sign(sel_sign),
    .dly_sign(dly_sign), .sd_count(sd_count), .sd_cap(sd_cap),
    .sd_valid(sd_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic signed [DW-1:0] d, input logic signed [DW-1:0] e,
                      input string tag, input bit rd);
    in_valid = 1'b1;
    in_data  = d;
    cap_rd   = rd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cap_rd   = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected output", int'(out_data), 0);
      end else begin
        automatic logic signed [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(out_data == e, t, int'(out_data), int'(e));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(out_valid == 0 && dly_sign == 0 && sd_count == 0 && sd_cap == 0 && sd_valid == 0,
        "R10 reset state", int'({out_valid, dly_sign, sd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(16'sd1234, 16'sd1234, "R1 positive passthrough", 1'b0);
    send(-16'sd300, -16'sd300, "R1 negative passthrough", 1'b0);
    rect_en = 1'b1;
    send(16'sd77, 16'sd77, "R2 positive half-wave unchanged", 1'b0);

    sgn_carrier = 1'b1;
    #1 chk(sel_sign == 1, "R4 carrier source", int'(sel_sign), 1);
    cycles(6);
    chk(dly_sign == 0, "R5 negative delay not yet", int'(dly_sign), 0);
    cycles(1);
    chk(dly_sign == 1, "R5 negative delay reached", int'(dly_sign), 1);

    send(16'sd100, -16'sd100, "R2 negated", 1'b0);
    send(-16'sd7, 16'sd7, "R2 negative negated", 1'b0);
    send(S_MIN, S_MAX, "R3 saturation", 1'b0);
    send(16'sd0, 16'sd0, "R2 zero", 1'b0);

    chk(sd_valid == 1, "R8 capture flag set", int'(sd_valid), 1);
    cap_rd = 1'b1;
    cycles(1);
    cap_rd = 1'b0;
    chk(sd_valid == 0, "R9 read clears", int'(sd_valid), 0);

    sgn_carrier = 1'b0;
    cycles(2);
    sgn_carrier = 1'b1;
    cycles(10);
    chk(dly_sign == 1, "R6 short pulse dropped", int'(dly_sign), 1);

    sgn_carrier = 1'b0;
    cycles(3);
    chk(dly_sign == 1, "R5 positive delay not yet", int'(dly_sign), 1);
    cycles(1);
    chk(dly_sign == 0, "R5 positive delay reached", int'(dly_sign), 0);

    for (int pass = 0; pass < 2; pass++) begin
      sgn_carrier = pass[0]; sgn_next = ~pass[0];
      sgn_ext_a = pass[0];   sgn_ext_b = ~pass[0];
      for (int s = 0; s < 4; s++) begin
        sign_src = s[1:0];
        #1 chk(sel_sign == (s[0] ^ pass[0]), "R4 source select",
               int'(sel_sign), int'(s[0] ^ pass[0]));
      end
    end
    sign_src = 2'd0; sgn_carrier = 1'b0; sgn_next = 1'b0;
    sgn_ext_a = 1'b0; sgn_ext_b = 1'b0;
    cycles(12);
    chk(dly_sign == 0, "R5 settled positive", int'(dly_sign), 0);

    sgn_carrier = 1'b1;
    cycles(10);
    chk(sd_count == 9, "R7 counter after transition", int'(sd_count), 9);
    send(-16'sd50, 16'sd50, "R2 negated during capture", 1'b0);
    chk(sd_cap == 9 && sd_valid == 1, "R8 captured lag", int'(sd_cap), 9);
    send(16'sd20, -16'sd20, "R2 negated during read", 1'b1);
    chk(sd_cap == 10 && sd_valid == 1, "R9 capture beats read", int'(sd_cap), 10);

    cycles(150);
    chk(sd_count == 127, "R7 counter holds at max", int'(sd_count), 127);
    rect_en = 1'b0;
    send(-16'sd9, -16'sd9, "R1 passthrough on negative half-wave", 1'b0);

    cycles(3);
    chk(exp_q.size() == 0, "R2 all results produced", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule